// File: doc/BRIEF.md
# Linked-Descriptor Receive DMA Channel

This block is one receive channel of a packet DMA engine. Software builds a chain of four-word buffer descriptors in a small local descriptor RAM, hands them to the engine by writing a head-pointer register, and grants buffer credits. The engine loads the descriptor at the head, waits for the next packet on a byte-stream input, writes the packet bytes into buffer memory through a byte write port, and then writes a completion status into the descriptor's mode word with the ownership flag cleared.

After a completion the engine reads the descriptor's link word. A nonzero link moves the head to the next descriptor. A zero link marks end-of-queue in the finished descriptor, clears the head register and stops the channel. The link is read only at completion, so software can extend a live chain by writing the tail's link word. It can restart a stopped channel by writing the head register again. A packet that cannot be placed, because the channel is off, there is no credit or no descriptor is armed, is discarded whole.

Top module: `rx_desc_dma`

## Requirements
- R1: A descriptor at word index p uses four RAM words: p+0 link (word index of the next descriptor, 0 = none), p+1 buffer byte address, p+2 buffer size in bytes (low 11 bits), p+3 mode/status. Writing a nonzero value to the head register (address 2) while the engine is idle arms the descriptor at that index.
- R2: The bytes of a captured packet go to consecutive buffer addresses starting at the buffer address. Bytes beyond the buffer size are discarded.
- R3: On completion the mode word becomes: bit 31 (start of packet) = 1, bit 30 (end of packet) = 1, bit 29 (owner) = 0, bit 28 (end of queue) as in R4, bits 10:0 = number of bytes stored, and all other bits 0.
- R4: If the link word is zero at completion, the end-of-queue bit is set, the engine halts and the head register reads 0. If the link is nonzero, end-of-queue stays 0 and the head register reads the link value.
- R5: The link word is read at completion, so a link written by software while a descriptor waits for its packet is followed with no restart.
- R6: After a halt, writing a new nonzero head value starts the engine again.
- R7: A head-register write while the engine is busy with a descriptor is ignored.
- R8: A write to the credit register (address 4) adds its low 8 bits to the credit count. Each captured packet uses one credit. The register reads back the count.
- R9: A packet whose first byte arrives while the channel is disabled (control register, address 0, bit 0), the credit count is 0, or no descriptor is armed is dropped whole: no buffer write, no descriptor change, no credit used.
- R10: If the armed descriptor's owner bit (bit 29) is 0 when loaded, the engine halts without touching it and the head register reads 0.
- R11: Writing bit 0 = 1 to the soft-reset register (address 1) makes it read 1 for one cycle. At the next cycle control, head, completion pointer and credit read 0 and the engine is idle.
- R12: The completion-pointer register (address 3) stores a software write and reads it back.
- R13: After the asynchronous reset all registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on address) |
| desc_we_i | input | 1 | Software descriptor RAM write strobe |
| desc_addr_i | input | DAW | Software descriptor RAM word index |
| desc_wdata_i | input | 32 | Software descriptor RAM write data |
| desc_rdata_o | output | 32 | Descriptor RAM read data at desc_addr_i |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_data_i | input | 8 | Receive byte |
| rx_last_i | input | 1 | Last byte of packet |
| buf_we_o | output | 1 | Buffer memory byte write strobe |
| buf_addr_o | output | 32 | Buffer memory byte address |
| buf_data_o | output | 8 | Buffer memory byte data |

## Verification
The hardest case to reach is the live append. Software has to rewrite the link word of a descriptor that the engine already holds, and the new link has to be followed without a restart. The bench arms a descriptor whose link is zero, waits until the engine is parked waiting for a packet, rewrites the link, and only then sends the packet. It then checks that the first descriptor completes without end-of-queue and that a second packet lands in the appended descriptor. Dropped packets are checked by sending one while the channel is off and then with no credit, and confirming that the descriptor, the buffer memory and the credit count are unchanged before granting the missing condition.

// File: rtl/rx_dma_pkg.sv
package rx_dma_pkg;
  localparam int MODE_SOP = 31;
  localparam int MODE_EOP = 30;
  localparam int MODE_OWN = 29;
  localparam int MODE_EOQ = 28;
  localparam int LEN_W    = 11;

  localparam logic [2:0] RA_CTRL   = 3'd0;
  localparam logic [2:0] RA_SRST   = 3'd1;
  localparam logic [2:0] RA_HEAD   = 3'd2;
  localparam logic [2:0] RA_DONE   = 3'd3;
  localparam logic [2:0] RA_CREDIT = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LOAD = 3'd1,
    ST_WAIT = 3'd2,
    ST_RUN  = 3'd3,
    ST_WB   = 3'd4
  } walk_st_e;
endpackage

// File: rtl/rx_dma_regs.sv
module rx_dma_regs
  import rx_dma_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [2:0]    addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  input  logic          walk_idle_i,
  input  logic          hw_head_we_i,
  input  logic [31:0]   hw_head_val_i,
  input  logic          credit_dec_i,
  output logic          en_o,
  output logic          srst_o,
  output logic [31:0]   head_o,
  output logic [CW-1:0] credit_o
);
  logic          en_q, srst_q;
  logic [31:0]   head_q, done_q;
  logic [CW-1:0] credit_q, credit_add;
  logic          wr_ok;

  assign wr_ok      = we_i && !srst_q;
  assign credit_add = (wr_ok && addr_i == RA_CREDIT) ? wdata_i[CW-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      srst_q   <= 1'b0;
      head_q   <= '0;
      done_q   <= '0;
      credit_q <= '0;
    end else if (srst_q) begin
      en_q     <= 1'b0;
      srst_q   <= 1'b0;
      head_q   <= '0;
      done_q   <= '0;
      credit_q <= '0;
    end else begin
      srst_q <= wr_ok && addr_i == RA_SRST && wdata_i[0];
      if (wr_ok && addr_i == RA_CTRL) en_q <= wdata_i[0];
      if (wr_ok && addr_i == RA_DONE) done_q <= wdata_i;
      if (hw_head_we_i) head_q <= hw_head_val_i;
      else if (wr_ok && addr_i == RA_HEAD && walk_idle_i) head_q <= wdata_i;
      credit_q <= credit_q + credit_add - CW'(credit_dec_i);
    end
  end

  always_comb begin
    case (addr_i)
      RA_CTRL:   rdata_o = {31'd0, en_q};
      RA_SRST:   rdata_o = {31'd0, srst_q};
      RA_HEAD:   rdata_o = head_q;
      RA_DONE:   rdata_o = done_q;
      RA_CREDIT: rdata_o = 32'(credit_q);
      default:   rdata_o = '0;
    endcase
  end

  assign en_o     = en_q;
  assign srst_o   = srst_q;
  assign head_o   = head_q;
  assign credit_o = credit_q;
endmodule

// File: rtl/rx_dma_desc_ram.sv
module rx_dma_desc_ram #(
  parameter int WORDS = 64,
  localparam int DAW  = $clog2(WORDS)
) (
  input  logic           clk_i,
  input  logic           sw_we_i,
  input  logic [DAW-1:0] sw_addr_i,
  input  logic [31:0]    sw_wdata_i,
  output logic [31:0]    sw_rdata_o,
  input  logic           eng_we_i,
  input  logic [DAW-1:0] eng_addr_i,
  input  logic [31:0]    eng_wdata_i,
  input  logic [DAW-1:0] base_i,
  output logic [31:0]    desc_o [4]
);
  logic [31:0] mem [WORDS];

  // engine write wins on a same-word collision
  always_ff @(posedge clk_i) begin
    if (sw_we_i)  mem[sw_addr_i]  <= sw_wdata_i;
    if (eng_we_i) mem[eng_addr_i] <= eng_wdata_i;
  end

  assign sw_rdata_o = mem[sw_addr_i];

  for (genvar g = 0; g < 4; g++) begin : g_word
    assign desc_o[g] = mem[base_i + DAW'(g)];
  end
endmodule

// File: rtl/rx_dma_walker.sv
module rx_dma_walker
  import rx_dma_pkg::*;
#(
  parameter int DAW = 6,
  parameter int CW  = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           srst_i,
  input  logic           en_i,
  input  logic [31:0]    head_i,
  input  logic [CW-1:0]  credit_i,
  input  logic [31:0]    d_next_i,
  input  logic [31:0]    d_buf_i,
  input  logic [31:0]    d_size_i,
  input  logic [31:0]    d_mode_i,
  input  logic           rx_valid_i,
  input  logic [7:0]     rx_data_i,
  input  logic           rx_last_i,
  output walk_st_e       st_o,
  output logic           head_we_o,
  output logic [31:0]    head_val_o,
  output logic           credit_dec_o,
  output logic           eng_we_o,
  output logic [DAW-1:0] eng_addr_o,
  output logic [31:0]    eng_wdata_o,
  output logic           buf_we_o,
  output logic [31:0]    buf_addr_o,
  output logic [7:0]     buf_data_o
);
  walk_st_e         st_q, st_d;
  logic [31:0]      bufp_q;
  logic [LEN_W-1:0] size_q, cnt_q;
  logic             in_pkt_q;
  logic             first_byte, take_first, take, room, eoq;

  assign first_byte = rx_valid_i && !in_pkt_q;
  assign take_first = st_q == ST_WAIT && first_byte && en_i && credit_i != '0;
  assign take       = take_first || (st_q == ST_RUN && rx_valid_i);
  assign room       = cnt_q < size_q;
  assign eoq        = d_next_i == '0;

  assign buf_we_o   = take && room;
  assign buf_addr_o = bufp_q + 32'(cnt_q);
  assign buf_data_o = rx_data_i;

  always_comb begin
    eng_wdata_o           = '0;
    eng_wdata_o[MODE_SOP] = 1'b1;
    eng_wdata_o[MODE_EOP] = 1'b1;
    eng_wdata_o[MODE_EOQ] = eoq;
    eng_wdata_o[LEN_W-1:0] = cnt_q;
  end
  assign eng_we_o     = st_q == ST_WB;
  assign eng_addr_o   = head_i[DAW-1:0] + DAW'(3);
  assign credit_dec_o = st_q == ST_WB;
  assign head_we_o    = st_q == ST_WB || (st_q == ST_LOAD && !d_mode_i[MODE_OWN]);
  assign head_val_o   = (st_q == ST_WB) ? d_next_i : '0;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (head_i != '0) st_d = ST_LOAD;
      ST_LOAD: st_d = d_mode_i[MODE_OWN] ? ST_WAIT : ST_IDLE;
      ST_WAIT: if (take_first) st_d = rx_last_i ? ST_WB : ST_RUN;
      ST_RUN:  if (rx_valid_i && rx_last_i) st_d = ST_WB;
      ST_WB:   st_d = eoq ? ST_IDLE : ST_LOAD;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      bufp_q   <= '0;
      size_q   <= '0;
      cnt_q    <= '0;
      in_pkt_q <= 1'b0;
    end else begin
      if (rx_valid_i) in_pkt_q <= !rx_last_i;
      if (srst_i) begin
        st_q  <= ST_IDLE;
        cnt_q <= '0;
      end else begin
        st_q <= st_d;
        if (st_q == ST_LOAD) begin
          bufp_q <= d_buf_i;
          size_q <= d_size_i[LEN_W-1:0];
        end
        if (st_q == ST_WB) cnt_q <= '0;
        else if (take && room) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign st_o = st_q;
endmodule

// File: rtl/rx_desc_dma.sv
module rx_desc_dma
  import rx_dma_pkg::*;
#(
  parameter int DESC_WORDS = 64,
  parameter int CREDIT_W   = 8,
  localparam int DAW       = $clog2(DESC_WORDS)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reg_we_i,
  input  logic [2:0]     reg_addr_i,
  input  logic [31:0]    reg_wdata_i,
  output logic [31:0]    reg_rdata_o,
  input  logic           desc_we_i,
  input  logic [DAW-1:0] desc_addr_i,
  input  logic [31:0]    desc_wdata_i,
  output logic [31:0]    desc_rdata_o,
  input  logic           rx_valid_i,
  input  logic [7:0]     rx_data_i,
  input  logic           rx_last_i,
  output logic           buf_we_o,
  output logic [31:0]    buf_addr_o,
  output logic [7:0]     buf_data_o
);
  walk_st_e            st;
  logic                en, srst_q, head_we, credit_dec, eng_we;
  logic [31:0]         head_q, head_val, eng_wdata;
  logic [CREDIT_W-1:0] credit_q;
  logic [DAW-1:0]      eng_addr;
  logic [31:0]         dw [4];

  rx_dma_regs #(.CW(CREDIT_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .walk_idle_i(st == ST_IDLE), .hw_head_we_i(head_we), .hw_head_val_i(head_val),
    .credit_dec_i(credit_dec), .en_o(en), .srst_o(srst_q), .head_o(head_q),
    .credit_o(credit_q)
  );

  rx_dma_desc_ram #(.WORDS(DESC_WORDS)) u_ram (
    .clk_i,
    .sw_we_i(desc_we_i), .sw_addr_i(desc_addr_i), .sw_wdata_i(desc_wdata_i),
    .sw_rdata_o(desc_rdata_o),
    .eng_we_i(eng_we), .eng_addr_i(eng_addr), .eng_wdata_i(eng_wdata),
    .base_i(head_q[DAW-1:0]), .desc_o(dw)
  );

  rx_dma_walker #(.DAW(DAW), .CW(CREDIT_W)) u_walk (
    .clk_i, .rst_ni, .srst_i(srst_q), .en_i(en), .head_i(head_q), .credit_i(credit_q),
    .d_next_i(dw[0]), .d_buf_i(dw[1]), .d_size_i(dw[2]), .d_mode_i(dw[3]),
    .rx_valid_i, .rx_data_i, .rx_last_i,
    .st_o(st), .head_we_o(head_we), .head_val_o(head_val), .credit_dec_o(credit_dec),
    .eng_we_o(eng_we), .eng_addr_o(eng_addr), .eng_wdata_o(eng_wdata),
    .buf_we_o, .buf_addr_o, .buf_data_o
  );
endmodule

// File: rtl/rx_desc_dma_chk.sv
module rx_desc_dma_chk
  import rx_dma_pkg::*;
#(
  parameter int CW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input walk_st_e      st,
  input logic [31:0]   head_q,
  input logic [31:0]   link,
  input logic [CW-1:0] credit_q,
  input logic          srst_q,
  input logic          reg_we_i,
  input logic [2:0]    reg_addr_i,
  input logic          buf_we_o
);
  assert_srst_selfclear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_q |=> !srst_q);

  assert_credit_no_underflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (credit_q == '0 && !(reg_we_i && reg_addr_i == RA_CREDIT)) |=> credit_q == '0);

  assert_write_needs_credit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_o |-> credit_q != '0);

  assert_halt_at_end_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_WB && link == '0) |=> (head_q == '0 && st == ST_IDLE));

  assert_busy_head_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == RA_HEAD && !srst_q && (st == ST_WAIT || st == ST_RUN))
    |=> head_q == $past(head_q));
endmodule

bind rx_desc_dma rx_desc_dma_chk #(.CW(CREDIT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .st(st), .head_q(head_q), .link(dw[0]),
  .credit_q(credit_q), .srst_q(srst_q), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .buf_we_o(buf_we_o)
);

// File: tb/rx_desc_dma_tb.sv
module rx_desc_dma_tb;
  localparam int DAW = 6;
  localparam logic [31:0] OWN = 32'h2000_0000;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic reg_we = 0, desc_we = 0, rx_valid = 0, rx_last = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, desc_wdata = 0, desc_rdata;
  logic [DAW-1:0] desc_addr = 0;
  logic [7:0] rx_data = 0, buf_data;
  logic buf_we;
  logic [31:0] buf_addr;
  logic [7:0] bmem [1024];
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rx_desc_dma u_dut (
    .clk_i(clk), .rst_ni, .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .desc_we_i(desc_we), .desc_addr_i(desc_addr),
    .desc_wdata_i(desc_wdata), .desc_rdata_o(desc_rdata), .rx_valid_i(rx_valid),
    .rx_data_i(rx_data), .rx_last_i(rx_last), .buf_we_o(buf_we), .buf_addr_o(buf_addr),
    .buf_data_o(buf_data)
  );

  always @(posedge clk) if (buf_we) bmem[buf_addr[9:0]] <= buf_data;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic desc_wr(input int a, input logic [31:0] d);
    @(negedge clk); desc_we = 1; desc_addr = DAW'(a); desc_wdata = d;
    @(negedge clk); desc_we = 0;
  endtask

  task automatic desc_rd(input int a, output logic [31:0] d);
    desc_addr = DAW'(a); #1; d = desc_rdata;
  endtask

  task automatic send_pkt(input int n, input int seed);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      rx_valid = 1; rx_data = 8'(seed * 16 + j); rx_last = (j == n - 1);
    end
    @(negedge clk); rx_valid = 0; rx_last = 0;
  endtask

  task automatic set_desc(input int p, input int link, input int ba, input int sz,
                          input logic [31:0] mode);
    desc_wr(p, 32'(link)); desc_wr(p + 1, 32'(ba)); desc_wr(p + 2, 32'(sz));
    desc_wr(p + 3, mode);
  endtask

  // count of bytes in [ba, ba+n) not matching the packet pattern
  function automatic int byte_errs(input int ba, input int n, input int seed);
    int e = 0;
    for (int j = 0; j < n; j++) if (bmem[ba + j] !== 8'(seed * 16 + j)) e++;
    return e;
  endfunction

  // pkt_len, buf_size, seed
  localparam int VEC [6][3] = '{
    '{5, 16, 1}, '{16, 16, 2}, '{20, 8, 3}, '{1, 4, 4}, '{3, 0, 5}, '{60, 64, 6}
  };

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int st, ba;
    for (int k = 0; k < 1024; k++) bmem[k] = 8'hEE;
    idle(3); rst_ni = 1; idle(2);

    // R13 reset state
    for (int a = 0; a < 5; a++) begin
      reg_rd(3'(a), v); chk("R13 reg after reset", v, 0);
    end

    // R12 completion pointer
    reg_wr(3, 32'h14); reg_rd(3, v); chk("R12 completion readback", v, 32'h14);

    reg_wr(0, 1);
    // vector loop: R1 R2 R3 R4 R6 R8
    for (int i = 0; i < 6; i++) begin
      ba = i * 128 + 8;
      st = (VEC[i][0] < VEC[i][1]) ? VEC[i][0] : VEC[i][1];
      set_desc(4, 0, ba, VEC[i][1], OWN);
      reg_wr(4, 1);
      reg_wr(2, 4);                       // R6: each pass restarts a halted channel
      idle(3);
      send_pkt(VEC[i][0], VEC[i][2]);
      idle(3);
      desc_rd(7, v); chk("R3 mode word", v, 32'hD000_0000 | 32'(st));
      reg_rd(2, v);  chk("R4 head cleared at end", v, 0);
      reg_rd(4, v);  chk("R8 credit consumed", v, 0);
      chk("R2 buffer bytes", 32'(byte_errs(ba, st, VEC[i][2])), 0);
      chk("R2 no write past size", {24'd0, bmem[ba + st]}, 32'hEE);
    end

    // R9 drop while disabled
    reg_wr(0, 0);
    set_desc(8, 0, 900, 16, OWN);
    reg_wr(4, 1); reg_wr(2, 8); idle(3);
    send_pkt(4, 7); idle(3);
    desc_rd(11, v); chk("R9 disabled: desc untouched", v, OWN);
    chk("R9 disabled: buffer untouched", {24'd0, bmem[900]}, 32'hEE);
    reg_rd(4, v); chk("R9 disabled: credit kept", v, 1);
    reg_wr(0, 1); send_pkt(4, 7); idle(3);
    desc_rd(11, v); chk("R9 enabled capture", v, 32'hD000_0004);

    // R9 drop with zero credit
    set_desc(12, 0, 920, 16, OWN);
    reg_wr(2, 12); idle(3);
    send_pkt(3, 8); idle(3);
    desc_rd(15, v); chk("R9 no credit: desc untouched", v, OWN);
    chk("R9 no credit: buffer untouched", {24'd0, bmem[920]}, 32'hEE);
    reg_wr(4, 1); send_pkt(3, 8); idle(3);
    desc_rd(15, v); chk("R9 credit granted capture", v, 32'hD000_0003);

    // R5 live append, R7 busy head write
    set_desc(16, 0, 940, 8, OWN);
    set_desc(20, 0, 960, 8, OWN);
    reg_wr(4, 2); reg_wr(2, 16); idle(3);
    desc_wr(16, 20);                      // link appended while waiting
    send_pkt(2, 9); idle(3);
    desc_rd(19, v); chk("R5 appended link: no end-of-queue", v, 32'hC000_0002);
    reg_rd(2, v); chk("R4 head follows link", v, 20);
    reg_wr(2, 24);
    reg_rd(2, v); chk("R7 busy head write ignored", v, 20);
    send_pkt(5, 10); idle(3);
    desc_rd(23, v); chk("R5 second descriptor", v, 32'hD000_0005);
    chk("R5 second buffer", 32'(byte_errs(960, 5, 10)), 0);

    // R10 not owned
    set_desc(24, 0, 980, 8, 32'h0);
    reg_wr(4, 1); reg_wr(2, 24); idle(3);
    reg_rd(2, v); chk("R10 head cleared", v, 0);
    send_pkt(2, 11); idle(3);
    desc_rd(27, v); chk("R10 desc untouched", v, 0);
    reg_rd(4, v); chk("R10 credit kept", v, 1);

    // R11 soft reset
    set_desc(28, 0, 1000, 8, OWN);
    reg_wr(3, 32'h55); reg_wr(2, 28); idle(2);
    reg_wr(1, 1);
    reg_rd(1, v); chk("R11 reset bit set", v, 1);
    @(negedge clk);
    reg_rd(1, v); chk("R11 self-clear", v, 0);
    reg_rd(0, v); chk("R11 control cleared", v, 0);
    reg_rd(2, v); chk("R11 head cleared", v, 0);
    reg_rd(3, v); chk("R11 completion cleared", v, 0);
    reg_rd(4, v); chk("R11 credit cleared", v, 0);
    reg_wr(0, 1); reg_wr(4, 1); send_pkt(2, 12); idle(3);
    desc_rd(31, v); chk("R11 engine idle after reset", v, OWN);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule